// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial memory holding 256 bytes in a register array. It oversamples the clock line and the data line with a faster system clock and finds start and stop conditions. It then decodes the device-select byte against a fixed memory-class prefix and three strap pins. The bus is open drain, so the block never drives the data line high. It only asserts a pull-down enable, and the pad pulls the line low when that enable is set.

A master stores one byte in three steps: it selects the device for writing, sends a word address, then sends the data byte. The write takes effect only when the master ends the frame with a stop. The stop then starts a self-timed programming interval of a set number of system clocks. During that interval the block ignores the bus completely and acknowledges nothing. Reads are single-byte. A read either continues from the internal pointer, or first moves the pointer with a dummy write of the word address followed by a repeated start.

Top module: `twi_mem_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start, and a rising data line while the clock line is high is a stop. A start received outside the programming interval restarts device-select reception from any state, including the middle of a byte.
- R2: The device-select byte is received most significant bit first. Bits 7..4 must be 1010 and bits 3..1 must equal strapPins[2:0], with bit 3 matching strapPins[2]. On a match the block pulls the data line low through the ninth clock. Bit 0 set to 1 selects a read and 0 selects a write.
- R3: On a mismatch the block does not pull the data line low on the ninth clock. It then ignores every further bit until the next start.
- R4: In a write frame the word address byte and the data byte are each acknowledged. The byte is stored at the word address only after a stop ends the frame.
- R5: From the stop that commits a write, the block stays in a programming interval of WRITE_CYCLES system clocks. In that interval it gives no acknowledge and ignores starts. Afterwards the byte is readable and the pointer equals the word address plus one.
- R6: A stop or repeated start that arrives before a stop has ended a complete write frame starts no programming interval. This includes a stop in the middle of the data byte and a repeated start after the data byte. The stored byte is unchanged, and the next device select is acknowledged at once.
- R7: A read-selected frame returns the byte at the pointer most significant bit first, then releases the line for the master's acknowledge bit. The pointer advances by one after the byte is sent.
- R8: A write-selected frame carrying only a word address, followed by a repeated start and a read select, returns the byte at that word address.
- R9: The pull-down enable changes only while the clock line is low.
- R10: After reset the pull-down enable is 0 and no programming interval is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level as seen on the wire |
| strapPins | input | 3 | Hard-wired device address bits |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
Two actions can be pending in the same cycle. One is the commit of a finished write frame, which waits for a stop. The other is a repeated start that opens a new frame. The bench completes a data byte with its acknowledge, then sends a repeated start in place of the stop. That start must win: the read select that follows is acknowledged at once with no programming interval, and it returns the old byte. A stop that cuts into the data byte is checked in the same way. The bench also sends a device select while the programming interval is running, where the start and the interval overlap, and expects no acknowledge.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_DEVACK,
    ST_WORDADDR,
    ST_WORDACK,
    ST_WDATA,
    ST_WDATAACK,
    ST_WAITSTOP,
    ST_RDATA,
    ST_RACK
  } ctrlState_t;

  // strobes from control into datapath
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic incPtr;
    logic holdData;
    logic startWrite;
    logic loadTx;
    logic shiftTx;
  } dpStrobes_t;

endpackage

// File: rtl/twi_mem_bus_sync.sv
module twi_mem_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic sclPrev, sdaPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclLvl <= 1'b1;
          sdaLvl <= 1'b1;
        end else begin
          sclLvl <= sclIn;
          sdaLvl <= sdaIn;
        end
      end
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
      assign sclLvl = sclPipe[SYNC_STAGES-1];
      assign sdaLvl = sdaPipe[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

  // a start and a stop cannot be seen in the same cycle
  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(startDet && stopDet)); // R1

endmodule

// File: rtl/twi_mem_datapath.sv
module twi_mem_datapath
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic              sdaLvl,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic              busy
);

  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int TIMER_W   = $clog2(WRITE_CYCLES + 1);
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(WRITE_CYCLES - 1);

  logic [BYTE_W-1:0] rxShift, txShift, wrData;
  logic [ADDR_W-1:0] ptr, wrAddr;
  logic [TIMER_W-1:0] timer;
  logic commit;
  logic [BYTE_W-1:0] mem [MEM_DEPTH];

  assign commit = busy && (timer == TIMER_LAST);
  assign rxByte = rxShift;
  assign txMsb  = txShift[BYTE_W-1];

  // serial receive register, sampled on SCL rising edges
  always_ff @(posedge clk) begin
    if (!rstN)               rxShift <= '0;
    else if (strobes.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaLvl};
  end

  // address pointer
  always_ff @(posedge clk) begin
    if (!rstN)               ptr <= '0;
    else if (commit)         ptr <= wrAddr + ADDR_W'(1);
    else if (strobes.loadPtr) ptr <= rxShift[ADDR_W-1:0];
    else if (strobes.incPtr)  ptr <= ptr + ADDR_W'(1);
  end

  // pending write held until the stop
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrData <= '0;
      wrAddr <= '0;
    end else if (strobes.holdData) begin
      wrData <= rxShift;
      wrAddr <= ptr;
    end
  end

  // self-timed programming interval
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      timer <= '0;
    end else if (strobes.startWrite) begin
      busy  <= 1'b1;
      timer <= '0;
    end else if (commit) begin
      busy  <= 1'b0;
    end else if (busy) begin
      timer <= timer + TIMER_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[wrAddr] <= wrData;
  end

  // serial transmit register, shifted on SCL falling edges
  always_ff @(posedge clk) begin
    if (!rstN)                txShift <= '1;
    else if (strobes.loadTx)  txShift <= mem[ptr];
    else if (strobes.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (timer <= TIMER_LAST)); // R5

  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.startWrite && !strobes.loadTx && !strobes.shiftIn); // R5

endmodule

// File: rtl/twi_mem_ctrl.sv
module twi_mem_ctrl
  import twi_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [2:0]        strapPins,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  input  logic              busy,
  output dpStrobes_t        strobes,
  output logic              sdaDriveLow
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  ctrlState_t state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic byteDone, byteDoneNext;
  logic ackDrive, ackDriveNext;
  logic sendMode, sendModeNext;
  logic addrMatch, isRead;

  assign addrMatch = (rxByte[7:4] == DEV_TYPE) && (rxByte[3:1] == strapPins);
  assign isRead    = rxByte[0];

  always_comb begin
    stateNext    = state;
    bitCntNext   = bitCnt;
    byteDoneNext = byteDone;
    ackDriveNext = ackDrive;
    sendModeNext = sendMode;
    strobes      = '0;
    if (busy) begin
      stateNext    = ST_IDLE;
      bitCntNext   = '0;
      byteDoneNext = 1'b0;
      ackDriveNext = 1'b0;
      sendModeNext = 1'b0;
    end else if (stopDet) begin
      stateNext          = ST_IDLE;
      bitCntNext         = '0;
      byteDoneNext       = 1'b0;
      ackDriveNext       = 1'b0;
      sendModeNext       = 1'b0;
      strobes.startWrite = (state == ST_WAITSTOP);
    end else if (startDet) begin
      stateNext    = ST_DEVADDR;
      bitCntNext   = '0;
      byteDoneNext = 1'b0;
      ackDriveNext = 1'b0;
      sendModeNext = 1'b0;
    end else begin
      unique case (state)
        ST_DEVADDR, ST_WORDADDR, ST_WDATA: begin
          if (sclRise && !byteDone) begin
            strobes.shiftIn = 1'b1;
            bitCntNext      = bitCnt + CNT_W'(1);
            byteDoneNext    = (bitCnt == LAST_BIT);
          end else if (sclFall && byteDone) begin
            byteDoneNext = 1'b0;
            bitCntNext   = '0;
            if (state == ST_DEVADDR) begin
              if (addrMatch) begin
                stateNext    = ST_DEVACK;
                ackDriveNext = 1'b1;
              end else begin
                stateNext = ST_IDLE;
              end
            end else if (state == ST_WORDADDR) begin
              stateNext       = ST_WORDACK;
              ackDriveNext    = 1'b1;
              strobes.loadPtr = 1'b1;
            end else begin
              stateNext        = ST_WDATAACK;
              ackDriveNext     = 1'b1;
              strobes.holdData = 1'b1;
            end
          end
        end
        ST_DEVACK: begin
          if (sclFall) begin
            ackDriveNext = 1'b0;
            if (isRead) begin
              stateNext      = ST_RDATA;
              strobes.loadTx = 1'b1;
              sendModeNext   = 1'b1;
            end else begin
              stateNext = ST_WORDADDR;
            end
          end
        end
        ST_WORDACK: begin
          if (sclFall) begin
            ackDriveNext = 1'b0;
            stateNext    = ST_WDATA;
          end
        end
        ST_WDATAACK: begin
          if (sclFall) begin
            ackDriveNext = 1'b0;
            stateNext    = ST_WAITSTOP;
          end
        end
        ST_RDATA: begin
          if (sclRise && !byteDone) begin
            bitCntNext   = bitCnt + CNT_W'(1);
            byteDoneNext = (bitCnt == LAST_BIT);
          end else if (sclFall && byteDone) begin
            sendModeNext   = 1'b0;
            byteDoneNext   = 1'b0;
            bitCntNext     = '0;
            strobes.incPtr = 1'b1;
            stateNext      = ST_RACK;
          end else if (sclFall) begin
            strobes.shiftTx = 1'b1;
          end
        end
        ST_RACK: begin
          if (sclRise) stateNext = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      ackDrive <= 1'b0;
      sendMode <= 1'b0;
    end else begin
      state    <= stateNext;
      bitCnt   <= bitCntNext;
      byteDone <= byteDoneNext;
      ackDrive <= ackDriveNext;
      sendMode <= sendModeNext;
    end
  end

  assign sdaDriveLow = ackDrive | (sendMode & ~txMsb);

  AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ackDrive) && state == ST_DEVACK) |->
      (rxByte[7:4] == DEV_TYPE) && (rxByte[3:1] == strapPins)); // R2

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !ackDrive && !sendMode); // R3

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (startDet && !busy) |=> (state == ST_DEVADDR) && (bitCnt == '0)); // R1

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 5000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapPins,
  output logic       sdaDriveLow
);

  import twi_mem_pkg::*;

  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [BYTE_W-1:0] rxByte;
  logic txMsb, busy;
  dpStrobes_t strobes;

  twi_mem_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sclLvl   (sclLvl),
    .sdaLvl   (sdaLvl),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet)
  );

  twi_mem_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .sclRise     (sclRise),
    .sclFall     (sclFall),
    .startDet    (startDet),
    .stopDet     (stopDet),
    .strapPins   (strapPins),
    .rxByte      (rxByte),
    .txMsb       (txMsb),
    .busy        (busy),
    .strobes     (strobes),
    .sdaDriveLow (sdaDriveLow)
  );

  twi_mem_datapath #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .sdaLvl  (sdaLvl),
    .rxByte  (rxByte),
    .txMsb   (txMsb),
    .busy    (busy)
  );

  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaDriveLow); // R5

  AST_WRITE_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopDet)); // R4

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclLvl); // R9

endmodule

// File: tb/sim_twi_mem_slave.sv
module sim_twi_mem_slave;

  localparam int QTR  = 8;
  localparam int WCYC = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sdaDriveLow;
  logic sdaLine;
  int nChecks = 0;
  int nFails = 0;
  int edgeViolations = 0;
  bit finished = 0;
  logic prevDrive = 1'b0;

  assign sdaLine = sdaM & ~sdaDriveLow;

  always #10 clk = ~clk;

  twi_mem_slave #(.WRITE_CYCLES(WCYC)) u0 (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclM),
    .sdaIn       (sdaLine),
    .strapPins   (strap),
    .sdaDriveLow (sdaDriveLow)
  );

  // R9 monitor: enable may change only while the clock line is low
  always @(negedge clk) begin
    if (rstN && (sdaDriveLow !== prevDrive) && sclM) edgeViolations++;
    prevDrive <= sdaDriveLow;
  end

  task automatic check(input string req, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdaM = b;    waitQ();
    sclM = 1'b1; waitQ();
    seen = sdaLine; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    acked = ~s;
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) clockBit(b[i], s);
  endtask

  task automatic recvByte(input logic masterAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      d[i] = s;
    end
    clockBit(~masterAck, s);
  endtask

  function automatic logic [7:0] devSel(input logic [2:0] pins, input logic rd);
    return {4'b1010, pins, rd};
  endfunction

  task automatic writeFrame(input logic [7:0] addr, input logic [7:0] data, input string req);
    logic a;
    startCond();
    sendByte(devSel(strap, 1'b0), a); check({req, " dev ack"}, a, 1);
    sendByte(addr, a);                 check({req, " word ack"}, a, 1);
    sendByte(data, a);                 check({req, " data ack"}, a, 1);
    stopCond();
  endtask

  task automatic waitProgram();
    repeat (WCYC + 100) @(negedge clk);
  endtask

  task automatic testReset();
    check("R10 drive after reset", sdaDriveLow, 0);
    check("R10 bus released", sdaLine, 1);
  endtask

  task automatic testMatch();
    logic a;
    startCond();
    sendByte(devSel(strap, 1'b0), a);
    check("R2 matching select acked", a, 1);
    stopCond();
    // no write frame: no programming interval, next select acked at once
    startCond();
    sendByte(devSel(strap, 1'b1), a);
    check("R6 select after empty frame acked", a, 1);
    stopCond();
  endtask

  task automatic testMismatch();
    logic a;
    startCond();
    sendByte(devSel(3'b100, 1'b0), a);
    check("R3 wrong strap no ack", a, 0);
    sendByte(devSel(strap, 1'b0), a);
    check("R3 ignored until start", a, 0);
    stopCond();
    startCond();
    sendByte({4'b1011, strap, 1'b0}, a);
    check("R3 wrong prefix no ack", a, 0);
    stopCond();
  endtask

  task automatic testWriteRead();
    logic a;
    logic [7:0] d;
    writeFrame(8'h13, 8'hA5, "R4");
    startCond();
    sendByte(devSel(strap, 1'b0), a);
    check("R5 no ack while programming", a, 0);
    stopCond();
    waitProgram();
    writeFrame(8'h12, 8'h3C, "R4");
    waitProgram();
    // pointer must now be 0x13
    startCond();
    sendByte(devSel(strap, 1'b1), a);
    check("R5 ack after interval", a, 1);
    recvByte(1'b0, d);
    check("R5 pointer is address plus one", d, 8'hA5);
    stopCond();
    // random read of 0x12
    startCond();
    sendByte(devSel(strap, 1'b0), a);
    sendByte(8'h12, a);
    check("R8 word address acked", a, 1);
    startCond();
    sendByte(devSel(strap, 1'b1), a);
    check("R8 read select acked", a, 1);
    recvByte(1'b0, d);
    check("R8 random read data", d, 8'h3C);
    stopCond();
    // pointer advanced after the read
    startCond();
    sendByte(devSel(strap, 1'b1), a);
    recvByte(1'b0, d);
    check("R7 current read after increment", d, 8'hA5);
    stopCond();
  endtask

  task automatic testAbort();
    logic a;
    logic [7:0] d;
    // stop in the middle of the data byte
    startCond();
    sendByte(devSel(strap, 1'b0), a);
    sendByte(8'h12, a);
    sendBits(8'h77, 4);
    stopCond();
    startCond();
    sendByte(devSel(strap, 1'b0), a);
    check("R6 no interval after partial byte", a, 1);
    stopCond();
    // full data byte, then repeated start instead of a stop
    startCond();
    sendByte(devSel(strap, 1'b0), a);
    sendByte(8'h12, a);
    sendByte(8'h77, a);
    check("R6 data acked before restart", a, 1);
    startCond();
    sendByte(devSel(strap, 1'b1), a);
    check("R6 restart select acked", a, 1);
    recvByte(1'b0, d);
    check("R6 byte unchanged", d, 8'h3C);
    stopCond();
  endtask

  task automatic testStartMidByte();
    logic a;
    startCond();
    sendBits(8'hFF, 3);
    startCond();
    sendByte(devSel(strap, 1'b0), a);
    check("R1 start inside a byte restarts", a, 1);
    stopCond();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testMatch();
    testMismatch();
    testWriteRead();
    testAbort();
    testStartMidByte();
    check("R9 drive changes only with SCL low", edgeViolations, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule